// File: doc/BRIEF.md
# Triple-Exposure HDR Line Combiner

This block takes an interleaved stream of 12-bit pixel samples. In every row time the stream carries three rows, each exposed for a different time: a long row, a mid row and a short row. The block turns them into one linear high-dynamic-range value per column, and that value is 20 bits wide. Each pixel comes with an exposure tag, a start-of-row flag and a start-of-frame flag. The long and mid rows are stored in two separate circular line memories. The short row is the output row. While it streams in, the long and mid samples that belong to the same physical row are read from the oldest slot of each memory. The three samples are then merged with two knee points.

The merge takes the first exposure that lies below a programmable saturation threshold. It rescales that exposure to the long-exposure scale with a run-time power-of-two ratio. A run-time mode then selects how the result leaves the block: plain 20-bit data, or a piecewise-linear curve that compresses it to 14 bits or to 12 bits. At the start of each frame the memories do not yet hold the matching rows. Until they do, the block rescales the short sample alone and drives its filled flag low.

Top module: `hdr_tri_combiner`

## Requirements
- R1: An output pixel (`out_valid` high) is produced exactly two clock cycles after each accepted short-exposure pixel (tag 2'b11), and in the same order as those pixels arrived. Long (2'b01) and mid (2'b10) pixels produce no output. Tag 2'b00 is never sent with `in_valid` high.
- R2: Within each row time the rows arrive in the order long, mid, short. The long sample used for a short pixel in column c is the long sample of column c that arrived `T1_LAG` row times earlier. A column is the count of valid pixels since the start-of-row pixel, and the start-of-row pixel is column 0.
- R3: The mid sample used for a short pixel in column c is the mid sample of column c that arrived `T2_LAG` row times earlier.
- R4: When the memories are primed and the long sample is below `cfg_thresh`, the linear result equals the long sample.
- R5: When the memories are primed, the long sample is at or above the threshold and the mid sample is below it, the result is the mid sample shifted left by `cfg_sh_mid`.
- R6: When the memories are primed and both the long and the mid sample are at or above the threshold, the result is the short sample shifted left by `cfg_sh_short`.
- R7: A shift setting above 8 acts as 8.
- R8: Counted from the start-of-frame pixel, the memories are primed once at least `T1_LAG`+1 long rows and `T2_LAG`+1 mid rows have started. Before that, the result is the short sample shifted by `cfg_sh_short` and `out_filled` is low. Once primed, `out_filled` is high.
- R9: When `cfg_mode` is 1, the output is y=x for x<4096, y=4096+((x-4096)>>2) for x<16384, and otherwise y=7168+((x-16384)>>7).
- R10: When `cfg_mode` is 2, the output is y=x for x<1024, y=1024+((x-1024)>>3) for x<8192, and otherwise y=1920+((x-8192)>>9).
- R11: When `cfg_mode` is 0 or 3, the output is the 20-bit linear result unchanged.
- R12: While reset is asserted, and right after it, `out_valid` is low.
- R13: A pixel with `in_sof` high restarts priming. The first `T1_LAG` short rows of every frame come out unfilled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_tag | input | 2 | Exposure tag: 1 long, 2 mid, 3 short |
| in_sol | input | 1 | First pixel of a row |
| in_sof | input | 1 | First pixel of a frame (first long pixel) |
| in_pix | input | IN_W | Pixel sample |
| cfg_thresh | input | IN_W | Saturation threshold |
| cfg_sh_mid | input | SHW | log2 of the long/mid exposure ratio |
| cfg_sh_short | input | SHW | log2 of the long/short exposure ratio |
| cfg_mode | input | 2 | 0/3 linear, 1 14-bit curve, 2 12-bit curve |
| out_valid | output | 1 | Output pixel present |
| out_sol | output | 1 | First output pixel of a row |
| out_filled | output | 1 | Long and mid data were available for this pixel |
| out_pix | output | OUT_W | Merged pixel, right-aligned when compressed |

## Verification
The in-line assertions watch four properties on every cycle. Every output must trace back to a short pixel two cycles earlier. Tags must be legal. The compressed outputs must stay within their 14-bit and 12-bit ranges. The memory slot must advance and the fill count must stay bounded at each row start.

Other properties only show up across whole frames of stimulus, so the bench's scenarios cover them. Each output must pair with the right long and mid rows from several row times before. Each branch must be selected correctly. Shift settings above 8 must be clamped. Every knee segment of both curves must be exact. The start of a frame must restart the unfilled period.

// File: rtl/hdr_pkg.sv
package hdr_pkg;

   typedef enum logic [1:0] {
      TAG_IDLE  = 2'd0,
      TAG_LONG  = 2'd1,
      TAG_MID   = 2'd2,
      TAG_SHORT = 2'd3
   } exp_tag_e;

   typedef enum logic [1:0] {
      CMP_LIN   = 2'd0,
      CMP_14    = 2'd1,
      CMP_12    = 2'd2,
      CMP_LIN_B = 2'd3
   } cmp_mode_e;

   // knee points and slopes of the two companding curves (20-bit input)
   localparam int unsigned C14_B1 = 4096;
   localparam int unsigned C14_B2 = 16384;
   localparam int unsigned C14_S1 = 2;
   localparam int unsigned C14_S2 = 7;
   localparam int unsigned C12_B1 = 1024;
   localparam int unsigned C12_B2 = 8192;
   localparam int unsigned C12_S1 = 3;
   localparam int unsigned C12_S2 = 9;

   // three-segment monotonic curve, identity below the first knee
   function automatic logic [19:0] knee3(input logic [19:0] x,
                                         input int unsigned b1,
                                         input int unsigned b2,
                                         input int unsigned s1,
                                         input int unsigned s2);
      logic [31:0] xv;
      xv = 32'(x);
      if (xv < b1)
         return x;
      else if (xv < b2)
         return 20'(b1 + ((xv - b1) >> s1));
      else
         return 20'(b1 + ((b2 - b1) >> s1) + ((xv - b2) >> s2));
   endfunction

endpackage

// File: rtl/hdr_line_delay.sv
module hdr_line_delay #(
   parameter int W    = 12,
   parameter int COLS = 16,
   parameter int LAG  = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       frame_start,
   input  logic                       wr_en,
   input  logic                       wr_sol,
   input  logic [$clog2(COLS)-1:0]    col,
   input  logic [W-1:0]               wr_data,
   output logic [W-1:0]               rd_data,
   output logic                       primed
);
   localparam int DEPTH = LAG + 1;
   localparam int SW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int ENT   = DEPTH * COLS;
   localparam int AW    = $clog2(ENT);
   localparam int FW    = $clog2(DEPTH + 1);

   if (LAG < 1) begin : g_bad_lag
      $error("hdr_line_delay: LAG must be at least 1");
   end
   if (COLS < 2) begin : g_bad_cols
      $error("hdr_line_delay: COLS must be at least 2");
   end

   logic [W-1:0]  mem [ENT];
   logic [SW-1:0] cur_q, nxt_slot, wr_slot;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [FW-1:0] fill_q;
   logic          row_start;

   always_comb begin
      nxt_slot  = (cur_q == SW'(DEPTH - 1)) ? '0 : cur_q + 1'b1;
      wr_slot   = wr_sol ? nxt_slot : cur_q;
      wr_addr   = AW'(int'(wr_slot) * COLS + int'(col));
      rd_addr   = AW'(int'(nxt_slot) * COLS + int'(col));
      row_start = wr_en && wr_sol;
   end

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= SW'(DEPTH - 1);
         fill_q <= '0;
      end else begin
         if (row_start) cur_q <= nxt_slot;
         if (row_start)
            fill_q <= frame_start ? FW'(1) :
                      (fill_q == FW'(DEPTH)) ? fill_q : fill_q + 1'b1;
         else if (frame_start)
            fill_q <= '0;
      end
   end

   assign rd_data = mem[rd_addr];
   assign primed  = (fill_q == FW'(DEPTH));

   // R2
   slot_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_start |=> (cur_q != $past(cur_q)));

   // R13
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_start && row_start) |=> (fill_q == FW'(1)));

endmodule

// File: rtl/hdr_merge.sv
module hdr_merge #(
   parameter int IN_W   = 12,
   parameter int MAX_SH = 8,
   parameter int SHW    = 4
) (
   input  logic [IN_W-1:0]        t_long,
   input  logic [IN_W-1:0]        t_mid,
   input  logic [IN_W-1:0]        t_short,
   input  logic                   primed,
   input  logic [IN_W-1:0]        thresh,
   input  logic [SHW-1:0]         sh_mid,
   input  logic [SHW-1:0]         sh_short,
   output logic [IN_W+MAX_SH-1:0] lin
);
   localparam int OW = IN_W + MAX_SH;

   logic [SHW-1:0] e_mid, e_short;

   always_comb begin
      e_mid   = (sh_mid   > SHW'(MAX_SH)) ? SHW'(MAX_SH) : sh_mid;
      e_short = (sh_short > SHW'(MAX_SH)) ? SHW'(MAX_SH) : sh_short;
      if (!primed)
         lin = OW'(t_short) << e_short;
      else if (t_long < thresh)
         lin = OW'(t_long);
      else if (t_mid < thresh)
         lin = OW'(t_mid) << e_mid;
      else
         lin = OW'(t_short) << e_short;
   end

endmodule

// File: rtl/hdr_compand.sv
module hdr_compand #(
   parameter int OUT_W = 20,
   parameter bit EN    = 1'b1
) (
   input  logic [OUT_W-1:0] lin,
   input  logic [1:0]       mode,
   output logic [OUT_W-1:0] y
);
   import hdr_pkg::*;

   if (EN) begin : g_curve
      if (OUT_W != 20) begin : g_bad_w
         $error("hdr_compand: curves are defined for a 20-bit input");
      end
      always_comb begin
         case (cmp_mode_e'(mode))
            CMP_14:  y = OUT_W'(knee3(20'(lin), C14_B1, C14_B2, C14_S1, C14_S2));
            CMP_12:  y = OUT_W'(knee3(20'(lin), C12_B1, C12_B2, C12_S1, C12_S2));
            default: y = lin;
         endcase
      end
   end else begin : g_pass
      logic unused_mode;
      assign unused_mode = ^mode;
      assign y = lin;
   end

endmodule

// File: rtl/hdr_tri_combiner.sv
module hdr_tri_combiner #(
   parameter int IN_W       = 12,
   parameter int MAX_SH     = 8,
   parameter int SHW        = 4,
   parameter int COLS       = 16,
   parameter int T1_LAG     = 4,
   parameter int T2_LAG     = 2,
   parameter bit COMPAND_EN = 1'b1,
   localparam int OUT_W     = IN_W + MAX_SH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [1:0]       in_tag,
   input  logic             in_sol,
   input  logic             in_sof,
   input  logic [IN_W-1:0]  in_pix,
   input  logic [IN_W-1:0]  cfg_thresh,
   input  logic [SHW-1:0]   cfg_sh_mid,
   input  logic [SHW-1:0]   cfg_sh_short,
   input  logic [1:0]       cfg_mode,
   output logic             out_valid,
   output logic             out_sol,
   output logic             out_filled,
   output logic [OUT_W-1:0] out_pix
);
   import hdr_pkg::*;

   localparam int CW = $clog2(COLS);

   if (T2_LAG >= T1_LAG) begin : g_bad_order
      $error("hdr_tri_combiner: T2_LAG must be below T1_LAG");
   end
   if (MAX_SH >= (1 << SHW)) begin : g_bad_shw
      $error("hdr_tri_combiner: SHW too narrow for MAX_SH");
   end

   logic [CW-1:0]   col_q, col_w;
   logic            frame_start, wr_long, wr_mid, is_short;
   logic [IN_W-1:0] rd_long, rd_mid;
   logic            pr_long, pr_mid;

   always_comb begin
      col_w       = in_sol ? '0 : col_q + 1'b1;
      frame_start = in_valid && in_sof;
      wr_long     = in_valid && (exp_tag_e'(in_tag) == TAG_LONG);
      wr_mid      = in_valid && (exp_tag_e'(in_tag) == TAG_MID);
      is_short    = in_valid && (exp_tag_e'(in_tag) == TAG_SHORT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        col_q <= '0;
      else if (in_valid) col_q <= col_w;
   end

   hdr_line_delay #(.W(IN_W), .COLS(COLS), .LAG(T1_LAG)) u_long_mem (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .wr_en(wr_long), .wr_sol(in_sol), .col(col_w), .wr_data(in_pix),
      .rd_data(rd_long), .primed(pr_long));

   hdr_line_delay #(.W(IN_W), .COLS(COLS), .LAG(T2_LAG)) u_mid_mem (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .wr_en(wr_mid), .wr_sol(in_sol), .col(col_w), .wr_data(in_pix),
      .rd_data(rd_mid), .primed(pr_mid));

   // stage 1: aligned exposure triple
   logic            s1_v, s1_sol, s1_primed;
   logic [IN_W-1:0] s1_long, s1_mid, s1_short;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v      <= 1'b0;
         s1_sol    <= 1'b0;
         s1_primed <= 1'b0;
         s1_long   <= '0;
         s1_mid    <= '0;
         s1_short  <= '0;
      end else begin
         s1_v      <= is_short;
         s1_sol    <= is_short && in_sol;
         s1_primed <= pr_long && pr_mid;
         if (is_short) begin
            s1_long  <= rd_long;
            s1_mid   <= rd_mid;
            s1_short <= in_pix;
         end
      end
   end

   // stage 2: merge and compress
   logic [OUT_W-1:0] lin, cmp;

   hdr_merge #(.IN_W(IN_W), .MAX_SH(MAX_SH), .SHW(SHW)) u_merge (
      .t_long(s1_long), .t_mid(s1_mid), .t_short(s1_short),
      .primed(s1_primed), .thresh(cfg_thresh),
      .sh_mid(cfg_sh_mid), .sh_short(cfg_sh_short), .lin(lin));

   hdr_compand #(.OUT_W(OUT_W), .EN(COMPAND_EN)) u_compand (
      .lin(lin), .mode(cfg_mode), .y(cmp));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_sol    <= 1'b0;
         out_filled <= 1'b0;
         out_pix    <= '0;
      end else begin
         out_valid  <= s1_v;
         out_sol    <= s1_sol;
         out_filled <= s1_v && s1_primed;
         if (s1_v) out_pix <= cmp;
      end
   end

   // R1
   short_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid && (in_tag == 2'd3), 2));

   // R1
   tag_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (in_tag != 2'd0));

   // R9
   cmp14_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(cfg_mode) == 2'd1) |-> (out_pix < OUT_W'(16384)));

   // R10
   cmp12_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(cfg_mode) == 2'd2) |-> (out_pix < OUT_W'(4096)));

endmodule

// File: tb/hdr_tri_combiner_tb_top.sv
module hdr_tri_combiner_tb_top;
   localparam int COLS = 16;
   localparam int L1   = 4;
   localparam int L2   = 2;
   localparam int NR   = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_tag = 2'd0;
   logic        in_sol = 1'b0;
   logic        in_sof = 1'b0;
   logic [11:0] in_pix = '0;
   logic [11:0] cfg_thresh = 12'd2048;
   logic [3:0]  cfg_sh_mid = 4'd0;
   logic [3:0]  cfg_sh_short = 4'd0;
   logic [1:0]  cfg_mode = 2'd0;
   logic        out_valid, out_sol, out_filled;
   logic [19:0] out_pix;

   always #4 clk = ~clk;

   hdr_tri_combiner #(.COLS(COLS), .T1_LAG(L1), .T2_LAG(L2)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
      .in_sol(in_sol), .in_sof(in_sof), .in_pix(in_pix),
      .cfg_thresh(cfg_thresh), .cfg_sh_mid(cfg_sh_mid),
      .cfg_sh_short(cfg_sh_short), .cfg_mode(cfg_mode),
      .out_valid(out_valid), .out_sol(out_sol), .out_filled(out_filled),
      .out_pix(out_pix));

   int checks = 0;
   int failures = 0;
   int hist1 [NR][COLS];
   int hist2 [NR][COLS];
   int    exp_data_q [$];
   bit    exp_fill_q [$];
   string exp_req_q  [$];

   task automatic check(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int eff(int s);
      return (s > 8) ? 8 : s;
   endfunction

   function automatic int curve(int x, int mode);
      if (mode == 1) begin
         if (x < 4096) return x;
         if (x < 16384) return 4096 + ((x - 4096) >> 2);
         return 7168 + ((x - 16384) >> 7);
      end
      if (mode == 2) begin
         if (x < 1024) return x;
         if (x < 8192) return 1024 + ((x - 1024) >> 3);
         return 1920 + ((x - 8192) >> 9);
      end
      return x;
   endfunction

   function automatic int pick(int thr);
      if ($urandom_range(0, 1) == 1) return int'($urandom_range(thr, 4095));
      return int'($urandom_range(0, thr - 1));
   endfunction

   task automatic send(int tag, bit sol, bit sof, int v);
      if ($urandom_range(0, 3) == 0) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_tag   = 2'(tag);
      in_sol   = sol;
      in_sof   = sof;
      in_pix   = 12'(v);
   endtask

   task automatic run_frame(int mode, int thr, int s12, int s13, bit later);
      @(negedge clk);
      in_valid     = 1'b0;
      cfg_mode     = 2'(mode);
      cfg_thresh   = 12'(thr);
      cfg_sh_mid   = 4'(s12);
      cfg_sh_short = 4'(s13);
      for (int k = 0; k < NR; k++) begin
         for (int c = 0; c < COLS; c++) begin
            hist1[k][c] = pick(thr);
            send(1, c == 0, (k == 0) && (c == 0), hist1[k][c]);
         end
         for (int c = 0; c < COLS; c++) begin
            hist2[k][c] = pick(thr);
            send(2, c == 0, 1'b0, hist2[k][c]);
         end
         for (int c = 0; c < COLS; c++) begin
            int v3, lin;
            bit primed;
            string req;
            v3 = pick(thr);
            primed = (k + 1 >= L1 + 1) && (k + 1 >= L2 + 1);
            if (!primed) begin
               lin = v3 << eff(s13);
               req = later ? "R8 R13" : "R8";
            end else if (hist1[k - L1][c] < thr) begin
               lin = hist1[k - L1][c];
               req = "R2 R4";
            end else if (hist2[k - L2][c] < thr) begin
               lin = hist2[k - L2][c] << eff(s12);
               req = (s12 > 8) ? "R3 R5 R7" : "R3 R5";
            end else begin
               lin = v3 << eff(s13);
               req = (s13 > 8) ? "R6 R7" : "R6";
            end
            if (mode == 1)      req = {req, " R9"};
            else if (mode == 2) req = {req, " R10"};
            else                req = {req, " R11"};
            exp_data_q.push_back(curve(lin, mode));
            exp_fill_q.push_back(primed);
            exp_req_q.push_back(req);
            send(3, c == 0, 1'b0, v3);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_data_q.size() == 0) begin
            check(1'b0, "R1 unexpected output", int'(out_pix), -1);
         end else begin
            int    ed;
            bit    ef;
            string er;
            ed = exp_data_q.pop_front();
            ef = exp_fill_q.pop_front();
            er = exp_req_q.pop_front();
            check(int'(out_pix) == ed, er, int'(out_pix), ed);
            check(out_filled == ef, "R8 filled flag", int'(out_filled), int'(ef));
         end
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R12 out_valid in reset", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R12 out_valid after reset", int'(out_valid), 0);
      run_frame(0, 3000, 2, 5, 1'b0);
      run_frame(1, 2048, 3, 7, 1'b1);
      run_frame(2, 4000, 12, 15, 1'b1);
      run_frame(3, 1000, 1, 9, 1'b1);
      run_frame(1, 500, 6, 8, 1'b1);
      check(exp_data_q.size() == 0, "R1 outputs missing", exp_data_q.size(), 0);
      finish_run();
   end

endmodule